// File: doc/BRIEF.md
# Memory-Mapped Serial Terminal Register Controller

This block is the register front end of a simple serial terminal device on a 32-bit memory-mapped bus. A character source pushes received bytes into an internal FIFO over a valid/ready handshake. Software sees how many bytes are waiting, sends single bytes out on a character stream, and programs a 64-bit buffer address and a 32-bit length. It also issues buffer-transfer commands, which are passed as a one-cycle pulse to a separate DMA mover. During a read-buffer transfer the mover drains the FIFO through a pop port.

A level interrupt is high whenever interrupts are enabled and the FIFO holds data. Enabling interrupts while bytes are already waiting raises the line at once. Reads complete in the same cycle as the access. Writes take effect at the clock edge that samples them.

Top module: `tty_mmio_ctrl`

## Requirements
- R1: After reset the FIFO is empty (byte count reads 0), `rx_ready` is 1, `irq` is 0, interrupts are disabled, and `dma_ptr` and `dma_len` are 0.
- R2: A read at offset 0x20 returns the constant 1.
- R3: A read at offset 0x04 returns the number of bytes in the receive FIFO. An accepted push adds one and a pop of a non-empty FIFO removes one. A push and a pop in the same cycle leave the count unchanged.
- R4: `rx_ready` is 0 exactly while the FIFO holds DEPTH bytes, and an offered byte is then not taken. Bytes leave through `rx_pop_data` in arrival order. `rx_pop_data` shows the oldest byte, and shows 0 when the FIFO is empty.
- R5: A write at offset 0x00 produces a one-cycle `tx_valid` pulse in the cycle after the write, with `tx_data` equal to bits 7:0 of the write data.
- R6: A write of value 1 at offset 0x08 enables interrupts and a write of value 0 disables them. `irq` is 1 exactly when interrupts are enabled and the byte count is non-zero, and it follows both in the cycle after either one changes.
- R7: A write at offset 0x10 loads `dma_ptr[31:0]` and clears `dma_ptr[63:32]`. A write at 0x18 loads `dma_ptr[63:32]` and keeps the low half. A write at 0x14 loads `dma_len`.
- R8: A write of value 2 (output from memory) or 3 (fill memory from the FIFO) at offset 0x08 gives a one-cycle `dma_cmd_valid` pulse in the next cycle. `dma_cmd_fill` is 1 for value 3 and 0 for value 2. Any other command value starts no transfer.
- R9: A read at an unaligned offset or at any offset other than 0x04 and 0x20 returns 0. A write at an unaligned offset, at a read-only offset, or at an offset outside the map has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | FIFO can take a byte |
| rx_pop | input | 1 | DMA mover removes the oldest byte |
| rx_pop_data | output | 8 | Oldest byte in the FIFO |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |
| dma_cmd_valid | output | 1 | Buffer transfer request pulse |
| dma_cmd_fill | output | 1 | 1 = FIFO to memory, 0 = memory to output |
| dma_ptr | output | 64 | Buffer address |
| dma_len | output | 32 | Buffer length |

## Verification
A byte arrival and a drain pop can land in the same cycle. This is the case where a count update could be lost or doubled. The bench raises `rx_valid` and `rx_pop` on the same edge while the FIFO is partly full. It expects the byte-count register to be unchanged, the popped byte to be the oldest one, and the new byte to come out later in order. The interrupt is also checked as the count crosses zero in both directions with the enable held, and as the enable toggles with the count held.

// File: rtl/tty_pkg.sv
package tty_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned PTR_W  = 64;

    // Register offsets (byte addresses, word aligned)
    localparam int unsigned OFF_TX     = 'h00;
    localparam int unsigned OFF_COUNT  = 'h04;
    localparam int unsigned OFF_CMD    = 'h08;
    localparam int unsigned OFF_PTR_LO = 'h10;
    localparam int unsigned OFF_LEN    = 'h14;
    localparam int unsigned OFF_PTR_HI = 'h18;
    localparam int unsigned OFF_VER    = 'h20;

    localparam logic [WORD_W-1:0] VERSION_VAL = 32'd1;

    // Command values
    localparam logic [WORD_W-1:0] CMD_IRQ_OFF = 32'd0;
    localparam logic [WORD_W-1:0] CMD_IRQ_ON  = 32'd1;
    localparam logic [WORD_W-1:0] CMD_XMIT    = 32'd2;
    localparam logic [WORD_W-1:0] CMD_FILL    = 32'd3;

    typedef struct packed {
        logic              tx_valid;
        logic [BYTE_W-1:0] tx_data;
        logic              cmd_valid;
        logic              cmd_fill;
        logic              int_en;
        logic [PTR_W-1:0]  ptr;
        logic [WORD_W-1:0] len;
    } reg_state_t;

endpackage

// File: rtl/tty_rx_fifo.sv
module tty_rx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 8,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [W-1:0]     push_data,
    output logic             push_ready,
    input  logic             pop_en,
    output logic [W-1:0]     pop_data,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [IDX_W-1:0] wr_idx;
        logic [IDX_W-1:0] rd_idx;
        logic [CNT_W-1:0] cnt;
    } fifo_state_t;

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    fifo_state_t      st_d, st_q;
    logic [W-1:0]     mem_q [DEPTH];
    logic             do_push, do_pop;

    assign push_ready = (st_q.cnt != FULL_CNT);
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop_en && (st_q.cnt != '0);
    assign pop_data   = (st_q.cnt != '0) ? mem_q[st_q.rd_idx] : '0;
    assign count      = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.wr_idx = (st_q.wr_idx == LAST_IDX) ? '0 : st_q.wr_idx + 1'b1;
        end
        if (do_pop) begin
            st_d.rd_idx = (st_q.rd_idx == LAST_IDX) ? '0 : st_q.rd_idx + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[st_q.wr_idx] <= push_data;
        end
    end

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1)
                 || (count + 1'b1 == $past(count)));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && !pop_en) |=> (count == FULL_CNT));

endmodule

// File: rtl/tty_reg_file.sv
module tty_reg_file
    import tty_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              cmd_valid,
    output logic              cmd_fill,
    output logic              int_en,
    output logic [PTR_W-1:0]  ptr,
    output logic [WORD_W-1:0] len
);

    reg_state_t st_d, st_q;
    logic       aligned;

    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        st_d           = st_q;
        st_d.tx_valid  = 1'b0;
        st_d.cmd_valid = 1'b0;
        if (wr_en && aligned) begin
            if (addr == ADDR_W'(OFF_TX)) begin
                st_d.tx_valid = 1'b1;
                st_d.tx_data  = wdata[BYTE_W-1:0];
            end
            if (addr == ADDR_W'(OFF_CMD)) begin
                case (wdata)
                    CMD_IRQ_OFF: st_d.int_en = 1'b0;
                    CMD_IRQ_ON:  st_d.int_en = 1'b1;
                    CMD_XMIT: begin
                        st_d.cmd_valid = 1'b1;
                        st_d.cmd_fill  = 1'b0;
                    end
                    CMD_FILL: begin
                        st_d.cmd_valid = 1'b1;
                        st_d.cmd_fill  = 1'b1;
                    end
                    default: ;
                endcase
            end
            if (addr == ADDR_W'(OFF_PTR_LO)) begin
                st_d.ptr = {{(PTR_W-WORD_W){1'b0}}, wdata};
            end
            if (addr == ADDR_W'(OFF_PTR_HI)) begin
                st_d.ptr = {wdata, st_q.ptr[WORD_W-1:0]};
            end
            if (addr == ADDR_W'(OFF_LEN)) begin
                st_d.len = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid  = st_q.tx_valid;
    assign tx_data   = st_q.tx_data;
    assign cmd_valid = st_q.cmd_valid;
    assign cmd_fill  = st_q.cmd_fill;
    assign int_en    = st_q.int_en;
    assign ptr       = st_q.ptr;
    assign len       = st_q.len;

    // R5
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_TX))
        |=> (tx_valid && tx_data == $past(wdata[BYTE_W-1:0])));

    // R7
    ptr_low_clears_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_PTR_LO))
        |=> (ptr[PTR_W-1:WORD_W] == '0 && ptr[WORD_W-1:0] == $past(wdata)));

    // R9
    unaligned_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[1:0] != 2'b00) |=> (!tx_valid && !cmd_valid && $stable(ptr) && $stable(len)));

endmodule

// File: rtl/tty_mmio_ctrl.sv
module tty_mmio_ctrl
    import tty_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    input  logic              rx_pop,
    output logic [7:0]        rx_pop_data,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq,
    output logic              dma_cmd_valid,
    output logic              dma_cmd_fill,
    output logic [63:0]       dma_ptr,
    output logic [31:0]       dma_len
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] fifo_count;
    logic             int_en;
    logic             wr_en;
    logic             rd_en;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    tty_rx_fifo #(
        .DEPTH (DEPTH),
        .W     (BYTE_W)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (rx_valid),
        .push_data  (rx_data),
        .push_ready (rx_ready),
        .pop_en     (rx_pop),
        .pop_data   (rx_pop_data),
        .count      (fifo_count)
    );

    tty_reg_file #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .cmd_valid (dma_cmd_valid),
        .cmd_fill  (dma_cmd_fill),
        .int_en    (int_en),
        .ptr       (dma_ptr),
        .len       (dma_len)
    );

    assign irq = int_en && (fifo_count != '0);

    always_comb begin
        bus_rdata = '0;
        if (rd_en && bus_addr[1:0] == 2'b00) begin
            if (bus_addr == ADDR_W'(OFF_COUNT)) begin
                bus_rdata = WORD_W'(fifo_count);
            end else if (bus_addr == ADDR_W'(OFF_VER)) begin
                bus_rdata = VERSION_VAL;
            end
        end
    end

    // R6
    irq_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADDR_W'(OFF_CMD) && bus_wdata == CMD_IRQ_OFF) |=> !irq);

    // R6
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADDR_W'(OFF_CMD) && bus_wdata == CMD_IRQ_ON && fifo_count > 1)
        |=> irq);

    // R2
    version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr == ADDR_W'(OFF_VER)) |-> (bus_rdata == 32'd1));

endmodule

// File: tb/tb_tty_mmio_ctrl.sv
module tb_tty_mmio_ctrl;

    localparam int unsigned DEPTH  = 4;
    localparam int unsigned ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_sel, bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0]       bus_wdata, bus_rdata;
    logic              rx_valid, rx_ready, rx_pop;
    logic [7:0]        rx_data, rx_pop_data;
    logic              tx_valid, irq, dma_cmd_valid, dma_cmd_fill;
    logic [7:0]        tx_data;
    logic [63:0]       dma_ptr;
    logic [31:0]       dma_len;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    bit exp_en = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tty_mmio_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq),
        .dma_cmd_valid(dma_cmd_valid), .dma_cmd_fill(dma_cmd_fill),
        .dma_ptr(dma_ptr), .dma_len(dma_len)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int unsigned a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int unsigned a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(a);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, input bit exp_ready);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        #1 check(rx_ready == exp_ready, "R4 rx_ready", 64'(rx_ready), 64'(exp_ready));
        @(negedge clk);
        rx_valid = 1'b0;
        if (exp_ready) exp_cnt++;
    endtask

    task automatic pop(input logic [7:0] exp_b);
        @(negedge clk);
        rx_pop = 1'b1;
        #1 check(rx_pop_data == exp_b, "R4 pop order", 64'(rx_pop_data), 64'(exp_b));
        @(negedge clk);
        rx_pop = 1'b0;
        exp_cnt--;
    endtask

    task automatic check_count(input string req);
        logic [31:0] r;
        bus_read('h04, r);
        check(r == 32'(exp_cnt), req, 64'(r), 64'(exp_cnt));
    endtask

    task automatic check_irq(input string req);
        bit e;
        e = exp_en && (exp_cnt != 0);
        check(irq == e, req, 64'(irq), 64'(e));
    endtask

    task automatic read_sweep();
        logic [31:0] r, e;
        for (int a = 0; a < 64; a++) begin
            bus_read(a, r);
            e = (a == 'h20) ? 32'd1 : (a == 'h04) ? 32'(exp_cnt) : 32'd0;
            check(r == e, (a == 'h20) ? "R2 version" : (a == 'h04) ? "R3 count" : "R9 unmapped read",
                  64'(r), 64'(e));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [63:0] eptr;
        logic [31:0] elen;
        rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        rx_valid = 0; rx_data = '0; rx_pop = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(irq == 1'b0, "R1 irq", 64'(irq), 0);
        check(rx_ready == 1'b1, "R1 rx_ready", 64'(rx_ready), 1);
        check(dma_ptr == '0, "R1 ptr", dma_ptr, 0);
        check(dma_len == '0, "R1 len", 64'(dma_len), 0);
        check(rx_pop_data == '0, "R4 empty pop data", 64'(rx_pop_data), 0);
        check_count("R1 count");
        read_sweep();

        // R3 R4 fill beyond full
        for (int i = 0; i <= DEPTH; i++) begin
            push(8'hA0 + 8'(i), i < DEPTH);
            check_count("R3 count after push");
        end
        read_sweep();
        for (int i = 0; i < DEPTH; i++) begin
            pop(8'hA0 + 8'(i));
            check_count("R3 count after pop");
        end
        check(rx_pop_data == '0, "R4 empty pop data", 64'(rx_pop_data), 0);

        // R3 simultaneous push and pop
        push(8'h11, 1'b1);
        push(8'h22, 1'b1);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h33; rx_pop = 1'b1;
        #1 check(rx_pop_data == 8'h11, "R3 pop during push", 64'(rx_pop_data), 64'h11);
        @(negedge clk);
        rx_valid = 1'b0; rx_pop = 1'b0;
        check_count("R3 count push+pop same cycle");

        // R6 interrupt combinations
        check_irq("R6 disabled with data");
        bus_write('h08, 32'd1); exp_en = 1; check_irq("R6 enable with data waiting");
        bus_write('h08, 32'd0); exp_en = 0; check_irq("R6 disable");
        pop(8'h22); pop(8'h33);
        check_irq("R6 disabled empty");
        bus_write('h08, 32'd1); exp_en = 1; check_irq("R6 enabled empty");
        push(8'h44, 1'b1); check_irq("R6 byte arrival");
        pop(8'h44); check_irq("R6 drain to empty");
        push(8'h55, 1'b1);
        bus_write('h08, 32'h100); check_irq("R6 odd value keeps enable");
        check(dma_cmd_valid == 1'b0, "R8 odd value no transfer", 64'(dma_cmd_valid), 0);

        // R5 transmit
        for (int v = 0; v < 8; v++) begin
            bus_write('h00, 32'h1234_5600 | 32'(v * 37));
            check(tx_valid == 1'b1, "R5 tx_valid", 64'(tx_valid), 1);
            check(tx_data == 8'(v * 37), "R5 tx_data", 64'(tx_data), 64'(8'(v * 37)));
            @(negedge clk);
            check(tx_valid == 1'b0, "R5 single pulse", 64'(tx_valid), 0);
        end

        // R7 pointer and length
        bus_write('h18, 32'hDEAD_BEEF);
        check(dma_ptr == 64'hDEAD_BEEF_0000_0000, "R7 ptr high", dma_ptr, 64'hDEAD_BEEF_0000_0000);
        bus_write('h10, 32'h1122_3344);
        check(dma_ptr == 64'h0000_0000_1122_3344, "R7 ptr low clears high", dma_ptr, 64'h1122_3344);
        bus_write('h18, 32'hCAFE_F00D);
        check(dma_ptr == 64'hCAFE_F00D_1122_3344, "R7 ptr high keeps low", dma_ptr, 64'hCAFE_F00D_1122_3344);
        bus_write('h14, 32'h0000_0100);
        check(dma_len == 32'h100, "R7 len", 64'(dma_len), 64'h100);

        // R8 command sweep
        for (int c = 0; c < 8; c++) begin
            bus_write('h08, 32'(c));
            if (c == 0) exp_en = 0;
            if (c == 1) exp_en = 1;
            check(dma_cmd_valid == (c == 2 || c == 3), "R8 cmd_valid", 64'(dma_cmd_valid), 64'(c == 2 || c == 3));
            if (c == 2 || c == 3)
                check(dma_cmd_fill == (c == 3), "R8 cmd_fill", 64'(dma_cmd_fill), 64'(c == 3));
            check_irq("R6 after command");
            @(negedge clk);
            check(dma_cmd_valid == 1'b0, "R8 single pulse", 64'(dma_cmd_valid), 0);
        end

        // R9 writes with no effect
        eptr = dma_ptr; elen = dma_len;
        for (int a = 0; a < 64; a++) begin
            if (a == 'h00 || a == 'h08 || a == 'h10 || a == 'h14 || a == 'h18) continue;
            bus_write(a, (a % 2 == 0) ? 32'd0 : 32'd2);
            check(tx_valid == 1'b0 && dma_cmd_valid == 1'b0, "R9 no strobe",
                  64'({tx_valid, dma_cmd_valid}), 0);
            check(dma_ptr == eptr && dma_len == elen, "R9 regs unchanged", dma_ptr, eptr);
            check_irq("R9 enable unchanged");
        end
        check_count("R9 count unchanged");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule